// File: doc/BRIEF.md
# Time-Spaced Double-Capture Checker

This block guards one combinational function against short transient faults without building a second copy of it. An operand is latched when a start strobe is accepted. The single logic path is then captured into two separate state registers at two moments. The second moment comes a fixed number of clock cycles after the first. Both capture moments are enable pulses inside one system clock domain.

After the second capture, the two samples are compared. If they agree, the value is committed to the output and marked valid. If they disagree, the block treats this as a transient, counts a retry and runs the whole two-capture sequence again. A bounded retry budget stops this: when the last allowed attempt still disagrees, the block raises a sticky error flag and does not commit.

A fault-injection mask input lets a test environment corrupt the logic output, but only during the first capture window. This allows the transient scenarios to be reproduced on demand.

Top module: `tr_sample_checker`

## Requirements
- R1: After reset, `dout` is 0, `dout_valid` is 0, `retry_count` is 0 and `persist_err` is 0.
- R2: The logic function is `f(x) = rotate_left_by_one(x) XOR MIX_PATTERN` (default pattern 8'hA5). When the two samples agree, `dout` becomes `f(din)` for the `din` seen on the accepted start edge.
- R3: The first capture happens on the clock edge after the start edge. The second capture happens exactly `SAMPLE_GAP` edges after the first. The compare follows one edge later. A run without retries therefore sets `dout_valid` `SAMPLE_GAP+2` edges after the start edge.
- R4: When the samples disagree and retries remain, `retry_count` increases by one and the full capture sequence repeats. Each retry adds `SAMPLE_GAP+2` edges of latency.
- R5: When the compare after `MAX_RETRY` retries still disagrees, `persist_err` is set, `retry_count` equals `MAX_RETRY`, `dout_valid` stays 0 and `dout` keeps its previous value.
- R6: `glitch_mask` is XORed into the logic output only in the first capture window. A mask applied while idle, or after the first capture, has no effect on `dout`.
- R7: A start pulse that arrives while an evaluation is in progress is ignored. The running evaluation completes with its original operand and latency, and no new evaluation begins.
- R8: `dout` changes only when a commit sets `dout_valid`. `dout_valid` and `persist_err` hold until the next accepted start, which clears both and resets `retry_count` to 0.
- R9: `dout_valid` and `persist_err` are never high together, and the two capture enables never fire in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an evaluation of `din` (taken only when idle) |
| din | input | DATA_W | Operand for the logic function |
| glitch_mask | input | DATA_W | Fault-injection mask, effective in the first capture window only |
| dout | output | DATA_W | Last committed result |
| dout_valid | output | 1 | Result of the latest evaluation is committed |
| retry_count | output | RETRY_W | Re-evaluations spent on the latest operand |
| persist_err | output | 1 | Retry budget exhausted without agreement |

## Verification
The bound checker watches several properties on every cycle:
- the spacing between the two capture enables and that they never overlap;
- the retry counter's bound and its one-step increment on each disagreement;
- that a commit is always preceded by an agreeing compare;
- that `dout` only moves on a commit;
- that valid and error are mutually exclusive.

Other properties need end-to-end stimulus, so only the bench scenarios can show them:
- the computed value of `f(din)`;
- the exact start-to-result latency with and without retries;
- that a mask outside the first window is harmless;
- that a start during a busy evaluation is dropped;
- that the previous result survives a persistent error.

// File: rtl/tr_pkg.sv
package tr_pkg;
  typedef enum logic [1:0] {
    TR_IDLE  = 2'd0,
    TR_PH1   = 2'd1,
    TR_SPACE = 2'd2,
    TR_CMP   = 2'd3
  } tr_state_e;
endpackage

// File: rtl/tr_phase_seq.sv
module tr_phase_seq
  import tr_pkg::*;
#(
  parameter int SAMPLE_GAP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic samples_match,
  input  logic retries_spent,
  output logic accept,
  output logic ph1_en,
  output logic ph2_en,
  output logic cmp_en
);
  localparam int GAP_W = $clog2(SAMPLE_GAP) + 1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(SAMPLE_GAP - 1);

  tr_state_e        state_q, state_d;
  logic [GAP_W-1:0] gap_q, gap_d;

  assign accept = (state_q == TR_IDLE) && start;
  assign ph1_en = (state_q == TR_PH1);
  assign ph2_en = (state_q == TR_SPACE) && (gap_q == GAP_LAST);
  assign cmp_en = (state_q == TR_CMP);

  always_comb begin
    state_d = state_q;
    gap_d   = gap_q;
    case (state_q)
      TR_IDLE:  if (start) state_d = TR_PH1;
      TR_PH1: begin
        state_d = TR_SPACE;
        gap_d   = '0;
      end
      TR_SPACE: begin
        if (ph2_en) state_d = TR_CMP;
        else        gap_d   = gap_q + 1'b1;
      end
      TR_CMP: begin
        if (samples_match || retries_spent) state_d = TR_IDLE;
        else                                state_d = TR_PH1;
      end
      default: state_d = TR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TR_IDLE;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      gap_q   <= gap_d;
    end
  end
endmodule

// File: rtl/tr_sample_regs.sv
module tr_sample_regs #(
  parameter int              DATA_W      = 8,
  parameter logic [DATA_W-1:0] MIX_PATTERN = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              ph1_en,
  input  logic              ph2_en,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] glitch_mask,
  output logic [DATA_W-1:0] second_sample,
  output logic              samples_match
);
  function automatic logic [DATA_W-1:0] eval_fn(input logic [DATA_W-1:0] x);
    return ((x << 1) | (x >> (DATA_W - 1))) ^ MIX_PATTERN;
  endfunction

  logic [DATA_W-1:0] operand_q, first_q, second_q, logic_out;

  assign logic_out     = eval_fn(operand_q) ^ (ph1_en ? glitch_mask : '0);
  assign second_sample = second_q;
  assign samples_match = (first_q == second_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      operand_q <= '0;
      first_q   <= '0;
      second_q  <= '0;
    end else begin
      if (accept) operand_q <= din;
      if (ph1_en) first_q   <= logic_out;
      if (ph2_en) second_q  <= logic_out;
    end
  end
endmodule

// File: rtl/tr_commit.sv
module tr_commit #(
  parameter int DATA_W    = 8,
  parameter int MAX_RETRY = 3,
  parameter int RETRY_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic               cmp_en,
  input  logic               samples_match,
  input  logic [DATA_W-1:0]  second_sample,
  output logic               retries_spent,
  output logic [DATA_W-1:0]  dout,
  output logic               dout_valid,
  output logic [RETRY_W-1:0] retry_count,
  output logic               persist_err
);
  logic [RETRY_W-1:0] retry_q;
  logic [DATA_W-1:0]  dout_q;
  logic               valid_q, err_q;

  assign retries_spent = (retry_q == RETRY_W'(MAX_RETRY));
  assign dout          = dout_q;
  assign dout_valid    = valid_q;
  assign retry_count   = retry_q;
  assign persist_err   = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retry_q <= '0;
      dout_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (accept) begin
      retry_q <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (cmp_en) begin
      if (samples_match) begin
        dout_q  <= second_sample;
        valid_q <= 1'b1;
      end else if (retries_spent) begin
        err_q   <= 1'b1;
      end else begin
        retry_q <= retry_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tr_sample_checker.sv
module tr_sample_checker #(
  parameter int                DATA_W      = 8,
  parameter int                SAMPLE_GAP  = 3,
  parameter int                MAX_RETRY   = 3,
  parameter logic [DATA_W-1:0] MIX_PATTERN = 8'hA5,
  localparam int               RETRY_W     = $clog2(MAX_RETRY + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [DATA_W-1:0]  din,
  input  logic [DATA_W-1:0]  glitch_mask,
  output logic [DATA_W-1:0]  dout,
  output logic               dout_valid,
  output logic [RETRY_W-1:0] retry_count,
  output logic               persist_err
);
  logic accept, ph1_en, ph2_en, cmp_en;
  logic samples_match, retries_spent;
  logic [DATA_W-1:0] second_sample;

  tr_phase_seq #(.SAMPLE_GAP(SAMPLE_GAP)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .samples_match(samples_match), .retries_spent(retries_spent),
    .accept(accept), .ph1_en(ph1_en), .ph2_en(ph2_en), .cmp_en(cmp_en)
  );

  tr_sample_regs #(.DATA_W(DATA_W), .MIX_PATTERN(MIX_PATTERN)) u_regs (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .ph1_en(ph1_en), .ph2_en(ph2_en),
    .din(din), .glitch_mask(glitch_mask),
    .second_sample(second_sample), .samples_match(samples_match)
  );

  tr_commit #(.DATA_W(DATA_W), .MAX_RETRY(MAX_RETRY), .RETRY_W(RETRY_W)) u_commit (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cmp_en(cmp_en),
    .samples_match(samples_match), .second_sample(second_sample),
    .retries_spent(retries_spent), .dout(dout), .dout_valid(dout_valid),
    .retry_count(retry_count), .persist_err(persist_err)
  );
endmodule

// File: rtl/tr_sample_checker_sva.sv
module tr_sample_checker_sva #(
  parameter int DATA_W     = 8,
  parameter int SAMPLE_GAP = 3,
  parameter int MAX_RETRY  = 3,
  parameter int RETRY_W    = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ph1_en,
  input logic               ph2_en,
  input logic               cmp_en,
  input logic               samples_match,
  input logic [DATA_W-1:0]  dout,
  input logic               dout_valid,
  input logic [RETRY_W-1:0] retry_count,
  input logic               persist_err
);
  logic [15:0] since_ph1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_ph1 <= '0;
    else if (ph1_en)           since_ph1 <= 16'd1;
    else if (since_ph1 != '1)  since_ph1 <= since_ph1 + 16'd1;
  end

  // R3
  gap_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph2_en |-> (since_ph1 == 16'(SAMPLE_GAP)));

  // R9
  phase_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph1_en && ph2_en));

  // R9
  valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dout_valid && persist_err));

  // R4
  retry_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && !samples_match && retry_count != RETRY_W'(MAX_RETRY))
      |=> (retry_count == $past(retry_count) + 1'b1));

  // R5
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    persist_err |-> (retry_count == RETRY_W'(MAX_RETRY)));

  // R8
  commit_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_valid) |-> $past(cmp_en && samples_match));

  // R8
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> dout_valid);
endmodule

bind tr_sample_checker tr_sample_checker_sva #(
  .DATA_W(DATA_W), .SAMPLE_GAP(SAMPLE_GAP), .MAX_RETRY(MAX_RETRY), .RETRY_W(RETRY_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .ph1_en(ph1_en), .ph2_en(ph2_en), .cmp_en(cmp_en),
  .samples_match(samples_match), .dout(dout), .dout_valid(dout_valid),
  .retry_count(retry_count), .persist_err(persist_err)
);

// File: tb/sim_tr_sample_checker.sv
module sim_tr_sample_checker;
  localparam int DW   = 8;
  localparam int GAP  = 3;
  localparam int MAXR = 3;
  localparam logic [DW-1:0] MIX = 8'hA5;
  localparam int RW   = $clog2(MAXR + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] glitch_mask = '0;
  logic [DW-1:0] dout;
  logic dout_valid, persist_err;
  logic [RW-1:0] retry_count;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tr_sample_checker #(.DATA_W(DW), .SAMPLE_GAP(GAP), .MAX_RETRY(MAXR), .MIX_PATTERN(MIX)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din), .glitch_mask(glitch_mask),
    .dout(dout), .dout_valid(dout_valid), .retry_count(retry_count), .persist_err(persist_err)
  );

  function automatic logic [DW-1:0] model_f(input logic [DW-1:0] x);
    return {x[DW-2:0], x[DW-1]} ^ MIX;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode: 0 clean, 1 glitch clears after first retry, 2 glitch held,
  //       3 glitch raised after first capture, 4 extra start while busy
  task automatic run_op(input logic [DW-1:0] operand, input int mode, output int lat);
    @(negedge clk);
    din = operand;
    start = 1'b1;
    if (mode == 1 || mode == 2) glitch_mask = 8'h10;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      lat++;
      if (mode == 1 && retry_count != 0) glitch_mask = '0;
      if (mode == 3 && lat == 1) glitch_mask = 8'hFF;
      if (mode == 4 && lat == 2) begin start = 1'b1; din = ~operand; end
      if (mode == 4 && lat == 3) start = 1'b0;
      if (dout_valid || persist_err) break;
    end
    glitch_mask = '0;
    start = 1'b0;
  endtask

  task automatic test_reset();
    chk("R1 dout", int'(dout), 0);
    chk("R1 valid", int'(dout_valid), 0);
    chk("R1 retry", int'(retry_count), 0);
    chk("R1 err", int'(persist_err), 0);
  endtask

  task automatic test_clean(input logic [DW-1:0] operand);
    int lat;
    run_op(operand, 0, lat);
    chk("R2 value", int'(dout), int'(model_f(operand)));
    chk("R3 latency", lat, GAP + 2);
    chk("R8 valid", int'(dout_valid), 1);
    chk("R8 retry cleared", int'(retry_count), 0);
  endtask

  task automatic test_one_retry(input logic [DW-1:0] operand);
    int lat;
    run_op(operand, 1, lat);
    chk("R4 value", int'(dout), int'(model_f(operand)));
    chk("R4 retry count", int'(retry_count), 1);
    chk("R4 latency", lat, 2 * (GAP + 2));
    chk("R4 valid", int'(dout_valid), 1);
  endtask

  task automatic test_persistent(input logic [DW-1:0] operand);
    int lat;
    logic [DW-1:0] prev;
    prev = dout;
    run_op(operand, 2, lat);
    chk("R5 err", int'(persist_err), 1);
    chk("R5 valid low", int'(dout_valid), 0);
    chk("R5 retry max", int'(retry_count), MAXR);
    chk("R5 dout kept", int'(dout), int'(prev));
    chk("R5 latency", lat, (MAXR + 1) * (GAP + 2));
    repeat (5) @(negedge clk);
    chk("R8 err held", int'(persist_err), 1);
  endtask

  task automatic test_late_glitch(input logic [DW-1:0] operand);
    int lat;
    run_op(operand, 3, lat);
    chk("R6 late mask value", int'(dout), int'(model_f(operand)));
    chk("R6 late mask no retry", int'(retry_count), 0);
    chk("R6 late mask latency", lat, GAP + 2);
  endtask

  task automatic test_idle_glitch();
    logic [DW-1:0] prev;
    prev = dout;
    @(negedge clk);
    glitch_mask = 8'h5A;
    repeat (6) @(negedge clk);
    chk("R6 idle mask dout", int'(dout), int'(prev));
    chk("R6 idle mask valid", int'(dout_valid), 1);
    glitch_mask = '0;
  endtask

  task automatic test_busy_start(input logic [DW-1:0] operand);
    int lat;
    logic [DW-1:0] res;
    run_op(operand, 4, lat);
    res = dout;
    chk("R7 original operand", int'(dout), int'(model_f(operand)));
    chk("R7 latency", lat, GAP + 2);
    repeat (2 * (GAP + 2)) @(negedge clk);
    chk("R7 no second run valid", int'(dout_valid), 1);
    chk("R7 no second run dout", int'(dout), int'(res));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        finished = 1;
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_clean(8'h3C);
    test_clean(8'h81);
    test_clean(8'h00);
    test_idle_glitch();
    test_one_retry(8'h47);
    test_persistent(8'hC3);
    test_clean(8'hFF);
    test_late_glitch(8'h12);
    test_busy_start(8'h6E);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule